// File: doc/BRIEF.md
# Serial Receive Start Strobe Generator with Frame Reject

This block watches a serial Ethernet receive bit stream, one bit per clock cycle, gated by a carrier-sense input. Bits arrive least-significant bit first, so the block compares them in arrival order. While carrier is present it hunts for the start-of-frame delimiter: an alternating preamble run closed by two consecutive ones. Once the delimiter is found, the block marks the frame as active.

An external address-matching device needs a timing reference. For it, the block raises a start strobe for exactly one bit time, during the cycle in which the second destination-address bit is on the receive input. That device, or any other agent, may then drive the reject input at any point in the frame. When carrier drops, the frame ends. In the cycle after that, the block pulses a discard flag if a reject was seen. The reject memory then clears for the next frame. Address matching, CRC checking and buffer storage belong to other blocks.

Top module: `rx_start_strobe`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `start_strobe`, `frame_active` and `discard` are all low.
- R2: With `crs` high, the delimiter is accepted on a received 1 whose preceding bit was also 1. That preceding bit must end an alternating run of at least PRE_MIN bits (default 6) with no carrier gap. `frame_active` goes high in the cycle after the final delimiter bit is presented.
- R3: `start_strobe` is high for exactly one cycle per frame. That cycle is the second cycle after the final delimiter bit, when destination-address bit 2 (STROBE_BIT, default 2) is on `rx_bit`. The strobe is never high in the first cycle of `frame_active`.
- R4: A preamble run that is too short, or a carrier loss while hunting, produces no `frame_active` and no strobe. Hunting restarts with an empty history after each carrier gap.
- R5: During a frame, a cycle with `crs` low ends the frame, and `frame_active` is low in the next cycle.
- R6: `reject_in` counts if it is high in any cycle from the first destination-address bit through the carrier-low cycle that ends the frame. In that case `discard` is high for exactly the one cycle after that carrier-low cycle. The next frame starts with no reject remembered.
- R7: `reject_in` is ignored while no frame is active, including the cycle that presents the final delimiter bit. Such a reject produces no `discard`.
- R8: If carrier drops while the first destination-address bit is due, the frame ends without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data, LSB first |
| crs | input | 1 | Carrier sense; low marks idle or end of frame |
| reject_in | input | 1 | Request to discard the frame in progress |
| start_strobe | output | 1 | One-bit-time strobe on destination-address bit 2 |
| frame_active | output | 1 | High from the first destination bit until the cycle after carrier loss |
| discard | output | 1 | One-cycle flag after frame end when a reject was seen |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both. In one scenario, `reject_in` is held high only in the cycle that presents destination bit 2, so the reject lands together with the strobe. In another, `reject_in` is high only in the carrier-low cycle that ends the frame, so the reject coincides with end of frame. In each case the bench expects both effects: the strobe still fires, and the discard pulse still appears in the cycle after carrier loss. The per-clock reference model decides these expectations from its own list of received bits and its own bit counter.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic in_frame;
        logic strobe;
        logic frame_end;
    } seq_out_t;

    function automatic logic alt_next(input logic have_prev, input logic prev, input logic cur);
        return have_prev && (prev != cur);
    endfunction

endpackage

// File: rtl/sfd_hunter.sv
module sfd_hunter #(
    parameter int PRE_MIN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic crs,
    input  logic enable,
    output logic hit
);
    import rxs_pkg::*;

    localparam int RW = $clog2(PRE_MIN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(PRE_MIN);

    logic          have_q;
    logic          last_q;
    logic [RW-1:0] run_q;

    // delimiter: two ones, the first closing a long enough alternating run
    always_comb begin
        hit = enable && crs && have_q && last_q && rx_bit && (run_q >= RUN_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst || !crs || !enable || hit) begin
            have_q <= 1'b0;
            last_q <= 1'b0;
            run_q  <= '0;
        end else begin
            have_q <= 1'b1;
            last_q <= rx_bit;
            if (alt_next(have_q, last_q, rx_bit)) begin
                run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            end else begin
                run_q <= RW'(1);
            end
        end
    end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
    parameter int STROBE_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crs,
    input  logic              hit,
    output rxs_pkg::seq_out_t so
);
    import rxs_pkg::*;

    localparam int CW = (STROBE_BIT > 2) ? $clog2(STROBE_BIT) : 1;
    localparam logic [CW-1:0] CNT_FIRE = CW'(STROBE_BIT - 2);
    localparam logic [CW-1:0] CNT_MAX  = CW'(STROBE_BIT - 1);

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    strobe_q <= 1'b0;
                    if (hit) begin
                        state_q <= ST_FRAME;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (!crs) begin
                        state_q  <= ST_HUNT;
                        strobe_q <= 1'b0;
                    end else begin
                        // register now so the strobe covers the next bit
                        strobe_q <= (cnt_q == CNT_FIRE);
                        if (cnt_q != CNT_MAX) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        so.in_frame  = (state_q == ST_FRAME);
        so.strobe    = strobe_q;
        so.frame_end = (state_q == ST_FRAME) && !crs;
    end

endmodule

// File: rtl/reject_tracker.sv
module reject_tracker (
    input  logic clk,
    input  logic rst,
    input  logic in_frame,
    input  logic frame_end,
    input  logic reject,
    output logic discard
);
    logic rej_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rej_q   <= 1'b0;
            discard <= 1'b0;
        end else if (frame_end) begin
            discard <= rej_q || reject;
            rej_q   <= 1'b0;
        end else begin
            discard <= 1'b0;
            if (in_frame && reject) begin
                rej_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_start_strobe.sv
module rx_start_strobe #(
    parameter int PRE_MIN    = 6,
    parameter int STROBE_BIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic crs,
    input  logic reject_in,
    output logic start_strobe,
    output logic frame_active,
    output logic discard
);
    import rxs_pkg::*;

    logic     sfd_hit;
    seq_out_t seq;

    sfd_hunter #(.PRE_MIN(PRE_MIN)) hunt_i (
        .clk    (clk),
        .rst    (rst),
        .rx_bit (rx_bit),
        .crs    (crs),
        .enable (!seq.in_frame),
        .hit    (sfd_hit)
    );

    frame_sequencer #(.STROBE_BIT(STROBE_BIT)) seq_i (
        .clk (clk),
        .rst (rst),
        .crs (crs),
        .hit (sfd_hit),
        .so  (seq)
    );

    reject_tracker rej_i (
        .clk       (clk),
        .rst       (rst),
        .in_frame  (seq.in_frame),
        .frame_end (seq.frame_end),
        .reject    (reject_in),
        .discard   (discard)
    );

    assign start_strobe = seq.strobe;
    assign frame_active = seq.in_frame;

endmodule

// File: rtl/rx_start_strobe_chk.sv
module rx_start_strobe_chk (
    input logic clk,
    input logic rst,
    input logic crs,
    input logic start_strobe,
    input logic frame_active,
    input logic discard
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_strobe |=> !start_strobe); // R3

    AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        start_strobe |-> frame_active); // R3

    AST_STROBE_NOT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> !start_strobe); // R3

    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !crs) |=> !frame_active); // R5

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!frame_active && !crs) |=> !frame_active); // R4

    AST_NO_STROBE_AFTER_LOSS: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !crs) |=> !start_strobe); // R8

    AST_DISCARD_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        discard |-> (!frame_active && $past(frame_active))); // R6

    AST_DISCARD_PULSE: assert property (@(posedge clk) disable iff (rst)
        discard |=> !discard); // R6

endmodule

bind rx_start_strobe rx_start_strobe_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .crs          (crs),
    .start_strobe (start_strobe),
    .frame_active (frame_active),
    .discard      (discard)
);

// File: tb/rx_start_strobe_tb_top.sv
`timescale 1ns/1ps
module rx_start_strobe_tb_top;

    localparam int PRE_MIN    = 6;
    localparam int STROBE_BIT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic crs = 1'b0;
    logic reject_in = 1'b0;
    logic start_strobe, frame_active, discard;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rx_start_strobe #(.PRE_MIN(PRE_MIN), .STROBE_BIT(STROBE_BIT)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .rx_bit       (rx_bit),
        .crs          (crs),
        .reject_in    (reject_in),
        .start_strobe (start_strobe),
        .frame_active (frame_active),
        .discard      (discard)
    );

    // ---------------- behavioural reference model ----------------
    bit   hist[$];
    bit   m_active = 0;
    int   m_cnt = 0;
    bit   m_rej = 0;
    logic exp_strobe = 0, exp_active = 0, exp_discard = 0;
    bit   cmp_en = 0;

    function automatic bit sfd_match();
        int n = hist.size();
        if (n < PRE_MIN + 1) return 0;
        if (!(hist[n-1] && hist[n-2])) return 0;
        for (int i = n - 1 - PRE_MIN; i < n - 2; i++)
            if (hist[i] == hist[i+1]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_active = 0; m_cnt = 0; m_rej = 0;
            exp_strobe = 0; exp_active = 0; exp_discard = 0;
        end else begin
            exp_strobe  = 0;
            exp_discard = 0;
            if (!m_active) begin
                if (!crs) hist.delete();
                else begin
                    hist.push_back(rx_bit);
                    if (hist.size() > PRE_MIN + 4) void'(hist.pop_front());
                    if (sfd_match()) begin
                        m_active = 1; m_cnt = 0; m_rej = 0;
                        hist.delete();
                    end
                end
            end else begin
                if (!crs) begin
                    exp_discard = m_rej || reject_in;
                    m_active = 0; m_rej = 0;
                end else begin
                    if (reject_in) m_rej = 1;
                    if (m_cnt == STROBE_BIT - 2) exp_strobe = 1;
                    m_cnt++;
                end
            end
            exp_active = m_active;
            cmp_en = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    int strobe_cnt = 0, disc_cnt = 0, act_cyc = 0;

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check(start_strobe === exp_strobe, "R3 strobe", start_strobe, exp_strobe);
            check(frame_active === exp_active, "R5 frame_active", frame_active, exp_active);
            check(discard === exp_discard, "R6 discard", discard, exp_discard);
            if (start_strobe) strobe_cnt++;
            if (discard) disc_cnt++;
            if (frame_active) act_cyc++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bitx(input logic b, input logic c, input logic r);
        @(negedge clk);
        rx_bit = b; crs = c; reject_in = r;
    endtask

    task automatic preamble(input int n, input logic r);
        for (int i = 0; i < n; i++) bitx(logic'((n - 1 - i) % 2), 1'b1, r);
    endtask

    task automatic sfd(input logic r);
        bitx(1'b1, 1'b1, r);
        bitx(1'b1, 1'b1, r);
    endtask

    task automatic body(input int n, input int rej_at);
        for (int i = 0; i < n; i++) bitx(logic'($urandom_range(0, 1)), 1'b1, logic'(i == rej_at));
    endtask

    task automatic finish_frame(input logic r);
        bitx(1'b0, 1'b0, r);
        for (int i = 0; i < 3; i++) bitx(1'b0, 1'b0, 1'b0);
    endtask

    int s0, d0, a0;
    task automatic snap();
        s0 = strobe_cnt; d0 = disc_cnt; a0 = act_cyc;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(start_strobe === 0 && frame_active === 0 && discard === 0, "R1 in reset",
              {start_strobe, frame_active, discard}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(start_strobe === 0 && frame_active === 0 && discard === 0, "R1 after reset",
              {start_strobe, frame_active, discard}, 0);

        // minimum preamble: run of exactly PRE_MIN before the last bit
        snap(); preamble(PRE_MIN - 1, 0); sfd(0); body(20, -1); finish_frame(0);
        check(act_cyc - a0 > 0, "R2 minimum run accepted", act_cyc - a0, 21);
        check(strobe_cnt - s0 == 1, "R3 one strobe per frame", strobe_cnt - s0, 1);
        check(disc_cnt - d0 == 0, "R6 no reject no discard", disc_cnt - d0, 0);

        // long preamble, reject mid frame
        snap(); preamble(56, 0); sfd(0); body(30, 12); finish_frame(0);
        check(strobe_cnt - s0 == 1, "R3 long preamble strobe", strobe_cnt - s0, 1);
        check(disc_cnt - d0 == 1, "R6 reject mid frame", disc_cnt - d0, 1);

        // following clean frame: reject memory cleared
        snap(); preamble(20, 0); sfd(0); body(25, -1); finish_frame(0);
        check(disc_cnt - d0 == 0, "R6 cleared for next frame", disc_cnt - d0, 0);

        // run one short of the minimum
        snap(); preamble(PRE_MIN - 2, 0); sfd(0); body(15, -1); finish_frame(0);
        check(act_cyc - a0 == 0, "R4 short run no frame", act_cyc - a0, 0);
        check(strobe_cnt - s0 == 0, "R4 short run no strobe", strobe_cnt - s0, 0);

        // carrier gap splits the preamble
        snap(); preamble(4, 0); bitx(0, 0, 0); preamble(3, 0); sfd(0); body(10, -1); finish_frame(0);
        check(strobe_cnt - s0 == 0, "R4 carrier gap restarts hunt", strobe_cnt - s0, 0);

        // reject while hunting and on delimiter bits
        snap(); preamble(16, 1); sfd(1); body(20, -1); finish_frame(0);
        check(disc_cnt - d0 == 0, "R7 reject outside frame ignored", disc_cnt - d0, 0);
        check(strobe_cnt - s0 == 1, "R7 frame still received", strobe_cnt - s0, 1);

        // reject only in the carrier-low end cycle
        snap(); preamble(16, 0); sfd(0); body(18, -1); finish_frame(1);
        check(disc_cnt - d0 == 1, "R6 reject in end cycle", disc_cnt - d0, 1);

        // reject in the strobe cycle (second destination bit)
        snap(); preamble(16, 0); sfd(0); body(18, 1); finish_frame(0);
        check(disc_cnt - d0 == 1, "R6 reject with strobe", disc_cnt - d0, 1);
        check(strobe_cnt - s0 == 1, "R3 strobe with reject", strobe_cnt - s0, 1);

        // carrier lost on the first destination bit
        snap(); preamble(16, 0); sfd(0); finish_frame(0);
        check(strobe_cnt - s0 == 0, "R8 no strobe after early loss", strobe_cnt - s0, 0);
        check(act_cyc - a0 == 1, "R5 frame closed after loss", act_cyc - a0, 1);

        // back-to-back frames with a single idle bit between
        snap(); preamble(10, 0); sfd(0); body(12, -1); bitx(0, 0, 0);
        preamble(10, 0); sfd(0); body(12, 5); finish_frame(0);
        check(strobe_cnt - s0 == 2, "R3 back-to-back strobes", strobe_cnt - s0, 2);
        check(disc_cnt - d0 == 1, "R6 back-to-back discard", disc_cnt - d0, 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule